// File: doc/BRIEF.md
# Windowed Regulation Watchdog Sequencer

This block is the digital side of a discrete-time corrective loop that sits beside a linear voltage regulator. On every tick of a monitoring oscillator it looks at two sampled comparator results. One says the regulated output is above the upper edge of a dead zone around its target. The other says it is below the lower edge. When exactly one of them is set, the block emits a corrective strobe for the power-device gate: a pull-up strobe when the output is high, and a pull-down strobe when the output is low. Inside the dead zone it does nothing, and the continuous-time amplifier keeps sole control.

The length of each strobe sets how much charge is injected. That length comes from a 2-bit strength word. A 2-bit rate word picks one of four oscillator speeds, and a 2-bit trim word sets the dead-zone width. All three come from a small settings table with one entry for each of eleven voltage codes. The entry is selected by the code currently in force. The table is filled through a plain address/data/write-enable port.

A global enable gates the whole function. When it is dropped, the oscillator enable falls and no strobes are produced.

Top module: `wdg_seq`

## Requirements
- R1: After reset, pull_up, pull_dn and osc_en are low, and charge_sel, rate_sel and dz_trim are all zero, because every table entry resets to zero.
- R2: osc_en equals the value wd_en had at the previous clock edge.
- R3: A tick with under_lo=1, over_hi=0 and wd_en=1, while no strobe is active, raises pull_dn from the next edge onward.
  - It stays high for exactly 1, 2, 4 or 8 cycles, for charge_sel values 0, 1, 2 or 3.
- R4: A tick with over_hi=1, under_lo=0 and wd_en=1, while no strobe is active, raises pull_up with the same length rule as R3.
- R5: A tick with both comparator inputs low produces no strobe.
- R6: A tick with both comparator inputs high is discarded and produces no strobe.
- R7: pull_up and pull_dn are never high in the same cycle.
- R8: While wd_en is low, no strobe is produced. Dropping wd_en during a strobe ends that strobe at the next edge.
- R9: A write with cfg_we=1 stores cfg_data into entry cfg_addr.
  - Field positions are: bits [1:0] strength, bits [3:2] rate, bits [5:4] trim.
  - charge_sel, rate_sel and dz_trim show the entry for vcode one edge after the entry and code are both in place.
- R10: Codes 11 to 15 on vcode read entry 10. Writes to addresses 11 to 15 are ignored.
- R11: A tick arriving while a strobe is active is ignored. The strobe keeps its original length.
- R12: Without a tick, comparator inputs have no effect on the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sequencing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wd_en | input | 1 | Global watchdog enable |
| tick | input | 1 | One-cycle monitoring tick, synchronous to clk |
| over_hi | input | 1 | Output above upper dead-zone edge |
| under_lo | input | 1 | Output below lower dead-zone edge |
| vcode | input | 4 | Voltage code now in force (0 to 10) |
| cfg_we | input | 1 | Settings table write enable |
| cfg_addr | input | 4 | Settings table write address |
| cfg_data | input | 6 | Entry data: [1:0] strength, [3:2] rate, [5:4] trim |
| osc_en | output | 1 | Monitoring oscillator enable |
| pull_up | output | 1 | Pull-up strobe for power-device gate |
| pull_dn | output | 1 | Pull-down strobe for power-device gate |
| charge_sel | output | 2 | Strength word for the current code |
| rate_sel | output | 2 | Oscillator rate select for the current code |
| dz_trim | output | 2 | Dead-zone trim for the current code |

## Verification
The bench programs distinct settings into several codes and measures each strobe length at the ports. A corrupted table entry or read-back path therefore shows up as a wrong settings word one edge after the code is applied. A wrong length counter shows up as a strobe that is too short or too long, visible within eight cycles of the tick. Stale busy state shows up as a missing or stretched strobe when a tick is repeated or the enable is dropped. A wrong direction decode shows up as the opposite strobe line in the first cycle after the tick.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;
    localparam int SEL_W = 2;
    localparam int CNT_W = (1 << SEL_W) - 1;

    typedef struct packed {
        logic [SEL_W-1:0] trim;
        logic [SEL_W-1:0] rate;
        logic [SEL_W-1:0] charge;
    } wd_cfg_t;

    localparam int CFG_W = $bits(wd_cfg_t);

    // remaining cycles after the first one of a strobe: 2^charge - 1
    function automatic logic [CNT_W-1:0] strobe_extra(input logic [SEL_W-1:0] charge);
        logic [CNT_W:0] one_hot;
        one_hot = (CNT_W+1)'(1) << charge;
        return CNT_W'(one_hot - 1'b1);
    endfunction
endpackage

// File: rtl/wdg_cfg_table.sv
`timescale 1ns/1ps
module wdg_cfg_table
    import wdg_pkg::*;
#(
    parameter int NUM_CODES = 11,
    parameter int CODE_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CODE_W-1:0] waddr,
    input  wd_cfg_t           wdata,
    input  logic [CODE_W-1:0] raddr,
    output wd_cfg_t           rdata
);
    localparam logic [CODE_W-1:0] LAST_CODE = CODE_W'(NUM_CODES - 1);

    typedef struct packed {
        wd_cfg_t [NUM_CODES-1:0] ent;
        wd_cfg_t                 rd;
    } tbl_state_t;

    tbl_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < NUM_CODES; i++) begin
            if (we && (waddr == CODE_W'(i))) begin
                s_d.ent[i] = wdata;
            end
        end
        if (raddr > LAST_CODE) begin
            s_d.rd = s_q.ent[NUM_CODES-1];
        end else begin
            s_d.rd = s_q.ent[raddr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata = s_q.rd;
endmodule

// File: rtl/wdg_decide.sv
`timescale 1ns/1ps
module wdg_decide (
    input  logic en,
    input  logic tick,
    input  logic hi,
    input  logic lo,
    output logic start,
    output logic dir_up
);
    logic one_side;

    always_comb begin
        one_side = hi ^ lo;
        start    = en && tick && one_side;
        dir_up   = hi;
    end
endmodule

// File: rtl/wdg_pulse_gen.sv
`timescale 1ns/1ps
module wdg_pulse_gen
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             start,
    input  logic             dir_up,
    input  logic [SEL_W-1:0] charge,
    output logic             pull_up,
    output logic             pull_dn
);
    typedef struct packed {
        logic             up;
        logic             dn;
        logic [CNT_W-1:0] cnt;
    } pg_state_t;

    pg_state_t s_d, s_q;
    logic      busy;

    always_comb begin
        s_d  = s_q;
        busy = s_q.up || s_q.dn;
        if (!en) begin
            s_d = '0;
        end else if (busy) begin
            if (s_q.cnt == '0) begin
                s_d.up = 1'b0;
                s_d.dn = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end else if (start) begin
            s_d.up  = dir_up;
            s_d.dn  = !dir_up;
            s_d.cnt = strobe_extra(charge);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pull_up = s_q.up;
    assign pull_dn = s_q.dn;
endmodule

// File: rtl/wdg_seq.sv
`timescale 1ns/1ps
module wdg_seq
    import wdg_pkg::*;
#(
    parameter int NUM_CODES = 11,
    parameter int CODE_W    = $clog2(NUM_CODES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wd_en,
    input  logic              tick,
    input  logic              over_hi,
    input  logic              under_lo,
    input  logic [CODE_W-1:0] vcode,
    input  logic              cfg_we,
    input  logic [CODE_W-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_data,
    output logic              osc_en,
    output logic              pull_up,
    output logic              pull_dn,
    output logic [SEL_W-1:0]  charge_sel,
    output logic [SEL_W-1:0]  rate_sel,
    output logic [SEL_W-1:0]  dz_trim
);
    typedef struct packed {
        logic osc_en;
    } top_state_t;

    top_state_t s_d, s_q;
    wd_cfg_t    cur_cfg;
    logic       start;
    logic       dir_up;

    always_comb begin
        s_d        = s_q;
        s_d.osc_en = wd_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    wdg_cfg_table #(
        .NUM_CODES(NUM_CODES),
        .CODE_W   (CODE_W)
    ) i_table (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (cfg_we),
        .waddr(cfg_addr),
        .wdata(wd_cfg_t'(cfg_data)),
        .raddr(vcode),
        .rdata(cur_cfg)
    );

    wdg_decide i_decide (
        .en    (wd_en),
        .tick  (tick),
        .hi    (over_hi),
        .lo    (under_lo),
        .start (start),
        .dir_up(dir_up)
    );

    wdg_pulse_gen i_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (wd_en),
        .start  (start),
        .dir_up (dir_up),
        .charge (cur_cfg.charge),
        .pull_up(pull_up),
        .pull_dn(pull_dn)
    );

    assign osc_en     = s_q.osc_en;
    assign charge_sel = cur_cfg.charge;
    assign rate_sel   = cur_cfg.rate;
    assign dz_trim    = cur_cfg.trim;
endmodule

// File: rtl/wdg_seq_chk.sv
`timescale 1ns/1ps
module wdg_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic wd_en,
    input logic tick,
    input logic over_hi,
    input logic under_lo,
    input logic osc_en,
    input logic pull_up,
    input logic pull_dn
);
    localparam int MAX_LEN = 8;

    logic [3:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (pull_up || pull_dn) begin
            if (run_len != 4'hF) run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    assert_osc_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wd_en |=> osc_en);
    assert_osc_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_en |=> !osc_en);
    assert_dn_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pull_dn) |-> $past(tick && under_lo && !over_hi && wd_en));
    assert_max_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= 4'(MAX_LEN));
    assert_up_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pull_up) |-> $past(tick && over_hi && !under_lo && wd_en));
    assert_band_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!over_hi && !under_lo && !pull_up && !pull_dn) |=> (!pull_up && !pull_dn));
    assert_both_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (over_hi && under_lo && !pull_up && !pull_dn) |=> (!pull_up && !pull_dn));
    assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(pull_up && pull_dn));
    assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_en |=> (!pull_up && !pull_dn));
endmodule

bind wdg_seq wdg_seq_chk i_wdg_seq_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wd_en   (wd_en),
    .tick    (tick),
    .over_hi (over_hi),
    .under_lo(under_lo),
    .osc_en  (osc_en),
    .pull_up (pull_up),
    .pull_dn (pull_dn)
);

// File: tb/test_wdg_seq.sv
`timescale 1ns/1ps
module test_wdg_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wd_en = 1'b0;
    logic       tick = 1'b0;
    logic       over_hi = 1'b0;
    logic       under_lo = 1'b0;
    logic [3:0] vcode = '0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [5:0] cfg_data = '0;
    logic       osc_en, pull_up, pull_dn;
    logic [1:0] charge_sel, rate_sel, dz_trim;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdg_seq i_wdg_seq (
        .clk(clk), .rst_n(rst_n), .wd_en(wd_en), .tick(tick),
        .over_hi(over_hi), .under_lo(under_lo), .vcode(vcode),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .osc_en(osc_en), .pull_up(pull_up), .pull_dn(pull_dn),
        .charge_sel(charge_sel), .rate_sel(rate_sel), .dz_trim(dz_trim)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [3:0] addr, input logic [5:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = addr; cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // apply a code and check the three settings words ({trim,rate,charge})
    task automatic check_cfg(input string req, input logic [3:0] code, input logic [5:0] exp);
        @(negedge clk);
        vcode = code;
        @(negedge clk);
        check(req, int'({dz_trim, rate_sel, charge_sel}), int'(exp));
    endtask

    // one tick with the given comparator pattern, then count strobe cycles
    task automatic run_pulse(input string req, input logic up, input logic dn,
                             input int retick_at, input int drop_at,
                             input int exp_up, input int exp_dn);
        int n_up = 0, n_dn = 0, n_both = 0;
        @(negedge clk);
        tick = 1'b1; over_hi = up; under_lo = dn;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (pull_up) n_up++;
            if (pull_dn) n_dn++;
            if (pull_up && pull_dn) n_both++;
            if (i == retick_at) begin
                tick = 1'b1; over_hi = up; under_lo = dn;
            end else begin
                tick = 1'b0; over_hi = 1'b0; under_lo = 1'b0;
            end
            if (i == drop_at) wd_en = 1'b0;
        end
        check({req, " pull_up cycles"}, n_up, exp_up);
        check({req, " pull_dn cycles"}, n_dn, exp_dn);
        check("R7 exclusive strobes", n_both, 0);
    endtask

    task automatic t_reset;
        check("R1 pull_up reset", int'(pull_up), 0);
        check("R1 pull_dn reset", int'(pull_dn), 0);
        check("R1 osc_en reset", int'(osc_en), 0);
        check("R1 settings reset", int'({dz_trim, rate_sel, charge_sel}), 0);
    endtask

    task automatic t_enable;
        @(negedge clk);
        wd_en = 1'b1;
        check("R2 osc_en lags enable", int'(osc_en), 0);
        @(negedge clk);
        check("R2 osc_en high", int'(osc_en), 1);
    endtask

    task automatic t_config;
        write_cfg(4'd0, 6'b01_11_00);
        write_cfg(4'd1, 6'b11_00_11);
        write_cfg(4'd3, 6'b10_01_10);
        write_cfg(4'd10, 6'b00_10_01);
        check_cfg("R9 code 3 entry", 4'd3, 6'b10_01_10);
        check_cfg("R9 code 0 entry", 4'd0, 6'b01_11_00);
        check_cfg("R9 code 1 entry", 4'd1, 6'b11_00_11);
        check_cfg("R10 code 15 reads entry 10", 4'd15, 6'b00_10_01);
        write_cfg(4'd12, 6'b11_11_11);
        check_cfg("R10 write to 12 ignored", 4'd12, 6'b00_10_01);
        check_cfg("R10 entry 10 intact", 4'd10, 6'b00_10_01);
    endtask

    task automatic t_strobes;
        check_cfg("R9 select code 0", 4'd0, 6'b01_11_00);
        run_pulse("R3 low output, strength 0", 1'b0, 1'b1, -1, -1, 0, 1);
        check_cfg("R9 select code 3", 4'd3, 6'b10_01_10);
        run_pulse("R3 low output, strength 2", 1'b0, 1'b1, -1, -1, 0, 4);
        check_cfg("R9 select code 1", 4'd1, 6'b11_00_11);
        run_pulse("R4 high output, strength 3", 1'b1, 1'b0, -1, -1, 8, 0);
        check_cfg("R10 select code 14", 4'd14, 6'b00_10_01);
        run_pulse("R10 clamped code, strength 1", 1'b0, 1'b1, -1, -1, 0, 2);
    endtask

    task automatic t_band;
        run_pulse("R5 inside dead zone", 1'b0, 1'b0, -1, -1, 0, 0);
        run_pulse("R6 both comparators set", 1'b1, 1'b1, -1, -1, 0, 0);
    endtask

    task automatic t_no_tick;
        int n = 0;
        @(negedge clk);
        under_lo = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (pull_up || pull_dn) n++;
        end
        under_lo = 1'b0;
        check("R12 no tick, no strobe", n, 0);
    endtask

    task automatic t_retick;
        check_cfg("R9 select code 1 again", 4'd1, 6'b11_00_11);
        run_pulse("R11 tick during strobe", 1'b0, 1'b1, 2, -1, 0, 8);
    endtask

    task automatic t_disable;
        run_pulse("R8 enable dropped mid-strobe", 1'b0, 1'b1, -1, 1, 0, 2);
        check("R8 osc_en low when disabled", int'(osc_en), 0);
        run_pulse("R8 disabled tick", 1'b0, 1'b1, -1, -1, 0, 0);
        @(negedge clk);
        wd_en = 1'b1;
        run_pulse("R8 re-enabled strobe", 1'b1, 1'b0, -1, -1, 8, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_config();
        t_strobes();
        t_band();
        t_no_tick();
        t_retick();
        t_disable();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule